// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block turns a packet held in a small byte store into line states on the two USB data wires at low-speed bit rate. A send request starts it. The block first drives the idle (J) state and takes the bus by raising output enable. It then sends a generated SYNC byte followed by the payload bytes, least significant bit first. The bits are NRZI-encoded and bit-stuffed. The packet ends with an end-of-packet sequence, after which the bus is released. The byte count given with a request includes the SYNC byte, so the block reads `byte_count - 1` payload bytes through its read port.

A second request input sends a handshake packet instead. This is SYNC plus one PID byte taken from a dedicated byte input, which is how ACK or NAK replies are produced. The block also keeps a pending device address written by the host side. It copies that address into the live address register only when a data packet finishes, never after a handshake. When the bus is released it pulses a flag that clears any receive-edge indication caused by the transmitter's own activity. Each bit lasts a parameterised number of clocks, so the start latency is a small fixed figure that fits the turnaround budget between packets.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, `oe`, `dp`, `dm`, `busy` and `pend_clr` are low and `dev_addr` is zero.
- R2: On the first clock edge that samples `start` or `hs_start` high while idle, `oe` rises with the line at J. J is held for exactly one bit time before the first SYNC bit.
- R3: J is driven as `dp`=0, `dm`=1 and K as `dp`=1, `dm`=0. Both pins are low whenever `oe` is low, and they are never high together.
- R4: A data packet sends the SYNC byte 0x80 followed by payload bytes read at `rd_idx` = 0, 1, ... up to `byte_count` - 2. Every byte goes out LSB first. A `byte_count` of 0 or 1 sends SYNC alone.
- R5: Line coding is NRZI: a 0 bit toggles the line between J and K, and a 1 bit keeps the current level.
- R6: After six consecutive 1 bits, one extra toggle is inserted and the run count restarts. This also happens when the run ends on the final bit of the packet.
- R7: End of packet drives both pins low (SE0) for two bit times, then J for one bit time, and then `oe` falls.
- R8: A `hs_start` request sends SYNC followed by the `hs_pid` byte sampled at the request, and nothing else.
- R9: `dev_addr` takes the last value written through `addr_we`/`addr_in` only at the release of a data packet. A handshake packet leaves it unchanged.
- R10: `pend_clr` is a one-clock pulse in the first cycle after `oe` falls, once per packet.
- R11: `start` and `hs_start` are ignored while `busy` is high, so the packet in flight goes out unchanged.
- R12: Every line state (lead J, data bit, stuffed bit, each SE0 bit, final J) lasts exactly `BIT_CLKS` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a data packet |
| byte_count | input | CNT_W | Packet length in bytes, including SYNC |
| rd_idx | output | CNT_W | Index of the payload byte being fetched |
| rd_data | input | 8 | Payload byte at `rd_idx` (combinational read) |
| hs_start | input | 1 | Request to send a handshake packet |
| hs_pid | input | 8 | Handshake PID byte |
| addr_we | input | 1 | Write strobe for the pending device address |
| addr_in | input | ADDR_W | Pending device address value |
| dev_addr | output | ADDR_W | Live device address |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Output enable for both data lines |
| busy | output | 1 | Packet in progress |
| pend_clr | output | 1 | Pulse to clear self-induced receive-edge indication |

## Verification
The bench builds the block with `BIT_CLKS` = 6, `CNT_W` = 4 and `ADDR_W` = 7. Short bit cells keep each packet to a few hundred clocks, so every-clock stability checks inside each cell stay cheap. A 4-bit count allows payloads long enough for two all-ones bytes in a row, which makes stuffing occur mid-byte, across byte boundaries, and on the final bit before SE0. The same settings reach the SYNC-only lengths 0 and 1, and the bench also interleaves handshakes with data packets to show when the address is committed.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LEAD,
    TX_DATA,
    TX_SE0,
    TX_EOPJ
  } tx_state_t;

  // SYNC pattern, LSB first: seven zeros then a one
  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam int unsigned STUFF_RUN = 6;

  // NRZI: line_k is 1 when the line is in K; a zero bit flips it
  function automatic logic nrzi_step(input logic line_k, input logic data_bit);
    return data_bit ? line_k : ~line_k;
  endfunction

  // next value of the consecutive-ones counter
  function automatic logic [2:0] run_step(input logic [2:0] run, input logic data_bit);
    return data_bit ? 3'(run + 3'd1) : 3'd0;
  endfunction

endpackage

// File: rtl/usb_ls_tx_bitclk.sv
module usb_ls_tx_bitclk #(
  parameter int unsigned BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_ls_tx_addr.sv
module usb_ls_tx_addr #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] din,
  input  logic              commit,
  output logic [ADDR_W-1:0] live
);
  logic [ADDR_W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      live   <= '0;
    end else begin
      if (wr)     pend_q <= din;
      if (commit) live   <= pend_q;
    end
  end
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 8,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [CNT_W-1:0]  rd_idx,
  input  logic [7:0]        rd_data,
  input  logic              hs_start,
  input  logic [7:0]        hs_pid,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              busy,
  output logic              pend_clr
);
  tx_state_t         state;
  logic              line_k;
  logic [7:0]        shreg;
  logic [3:0]        bits_rem;
  logic [CNT_W-1:0]  bytes_left;
  logic [CNT_W-1:0]  rd_idx_q;
  logic [2:0]        ones_q;
  logic              hs_q;
  logic [7:0]        hs_byte_q;
  logic              se0_late;
  logic              pend_clr_q;

  // named internal events
  logic       bit_tick;
  logic       in_ser;
  logic       stuff_now;
  logic       ser_end;
  logic       eop_done;
  logic       commit;
  logic       req_data;
  logic       req_hs;
  logic [7:0] next_byte;
  logic       cur_bit;

  assign req_data  = (state == TX_IDLE) && start;
  assign req_hs    = (state == TX_IDLE) && !start && hs_start;
  assign in_ser    = (state == TX_LEAD) || (state == TX_DATA);
  assign next_byte = hs_q ? hs_byte_q : rd_data;
  assign cur_bit   = (bits_rem == 4'd0) ? next_byte[0] : shreg[0];
  assign stuff_now = bit_tick && in_ser && (ones_q == 3'(STUFF_RUN));
  assign ser_end   = bit_tick && in_ser && !stuff_now &&
                     (bits_rem == 4'd0) && (bytes_left == '0);
  assign eop_done  = bit_tick && (state == TX_EOPJ);
  assign commit    = eop_done && !hs_q;

  usb_ls_tx_bitclk #(.BIT_CLKS(BIT_CLKS)) u_bitclk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state != TX_IDLE),
    .tick (bit_tick)
  );

  usb_ls_tx_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (addr_we),
    .din   (addr_in),
    .commit(commit),
    .live  (dev_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TX_IDLE;
      line_k     <= 1'b0;
      shreg      <= '0;
      bits_rem   <= '0;
      bytes_left <= '0;
      rd_idx_q   <= '0;
      ones_q     <= '0;
      hs_q       <= 1'b0;
      hs_byte_q  <= '0;
      se0_late   <= 1'b0;
      pend_clr_q <= 1'b0;
    end else begin
      pend_clr_q <= eop_done;
      unique case (state)
        TX_IDLE: begin
          if (req_data || req_hs) begin
            state    <= TX_LEAD;
            line_k   <= 1'b0;
            shreg    <= SYNC_BYTE;
            bits_rem <= 4'd8;
            ones_q   <= '0;
            rd_idx_q <= '0;
            hs_q     <= req_hs;
            if (req_hs) hs_byte_q <= hs_pid;
            if (req_hs)                 bytes_left <= CNT_W'(1);
            else if (byte_count == '0)  bytes_left <= '0;
            else                        bytes_left <= byte_count - 1'b1;
          end
        end
        TX_LEAD, TX_DATA: begin
          if (ser_end) begin
            state    <= TX_SE0;
            se0_late <= 1'b0;
          end else if (bit_tick) begin
            state <= TX_DATA;
            if (stuff_now) begin
              line_k <= ~line_k;
              ones_q <= '0;
            end else begin
              line_k <= nrzi_step(line_k, cur_bit);
              ones_q <= run_step(ones_q, cur_bit);
              if (bits_rem == 4'd0) begin
                shreg      <= {1'b0, next_byte[7:1]};
                bits_rem   <= 4'd7;
                bytes_left <= bytes_left - 1'b1;
                rd_idx_q   <= rd_idx_q + 1'b1;
              end else begin
                shreg    <= {1'b0, shreg[7:1]};
                bits_rem <= bits_rem - 4'd1;
              end
            end
          end
        end
        TX_SE0: begin
          if (bit_tick) begin
            if (se0_late) begin
              state  <= TX_EOPJ;
              line_k <= 1'b0;
            end else begin
              se0_late <= 1'b1;
            end
          end
        end
        TX_EOPJ: begin
          if (bit_tick) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign rd_idx   = rd_idx_q;
  assign oe       = (state != TX_IDLE);
  assign busy     = oe;
  assign pend_clr = pend_clr_q;
  assign dp       = oe && (state != TX_SE0) && line_k;
  assign dm       = oe && (state != TX_SE0) && !line_k;

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk
  import usb_ls_tx_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dp,
  input logic              dm,
  input logic              oe,
  input logic              pend_clr,
  input logic              hs_q,
  input logic              bit_tick,
  input logic [2:0]        ones_q,
  input logic [ADDR_W-1:0] dev_addr
);
  // R3
  no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp && dm));

  // R3
  released_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dp && !dm));

  // R2
  acquire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (dm && !dp));

  // R10
  clr_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> (!oe && $past(oe)));

  // R9
  addr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> (pend_clr && !hs_q));

  // R6
  run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= 3'(STUFF_RUN));

  // R12
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

bind usb_ls_tx usb_ls_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dp      (dp),
  .dm      (dm),
  .oe      (oe),
  .pend_clr(pend_clr),
  .hs_q    (hs_q),
  .bit_tick(bit_tick),
  .ones_q  (ones_q),
  .dev_addr(dev_addr)
);

// File: tb/usb_ls_tx_bench.sv
module usb_ls_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 6;
  localparam int CNT_W      = 4;
  localparam int ADDR_W     = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              hs_start = 1'b0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [7:0]        hs_pid = '0;
  logic [CNT_W-1:0]  rd_idx;
  logic [7:0]        rd_data;
  logic              addr_we = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] dev_addr;
  logic              dp, dm, oe, busy, pend_clr;
  logic [7:0]        mem [16];

  int checks = 0;
  int errors = 0;
  int clr_seen = 0;
  int exp_q[$];
  bit done = 1'b0;

  assign rd_data = mem[rd_idx];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ls_tx #(.BIT_CLKS(BIT_CLKS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_usb_ls_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .rd_idx(rd_idx), .rd_data(rd_data), .hs_start(hs_start), .hs_pid(hs_pid),
    .addr_we(addr_we), .addr_in(addr_in), .dev_addr(dev_addr),
    .dp(dp), .dm(dm), .oe(oe), .busy(busy), .pend_clr(pend_clr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (pend_clr) clr_seen++;

  // one line cell: value at its first negedge, stable through all BIT_CLKS clocks
  task automatic sample_cell(output logic [2:0] v);
    bit steady = 1'b1;
    v = {oe, dp, dm};
    for (int i = 1; i < BIT_CLKS; i++) begin
      @(negedge clk);
      if ({oe, dp, dm} != v) steady = 1'b0;
    end
    check(steady, "R12 cell held for BIT_CLKS", {29'd0, oe, dp, dm}, {29'd0, v});
    @(negedge clk);
  endtask

  // monitor: decode NRZI and stuffing, compare bytes to the scoreboard
  task automatic decode();
    logic [2:0] v;
    bit prev_k = 1'b0;
    bit k, b;
    bit stuff_pend = 1'b0;
    int ones = 0;
    int nb = 0;
    int exp;
    logic [7:0] acc = '0;
    sample_cell(v);
    check(v == 3'b101, "R2 lead cell is J", {29'd0, v}, 5);
    forever begin
      sample_cell(v);
      if (v[1:0] == 2'b00) break;
      check(v[1] != v[0], "R3 legal J/K", {29'd0, v}, 5);
      k = v[1];
      if (stuff_pend) begin
        check(k != prev_k, "R6 stuffed toggle", {31'd0, k}, {31'd0, !prev_k});
        stuff_pend = 1'b0;
        ones = 0;
        prev_k = k;
        continue;
      end
      b = (k == prev_k);
      prev_k = k;
      ones = b ? ones + 1 : 0;
      if (ones == 6) stuff_pend = 1'b1;
      acc[nb] = b;
      nb++;
      if (nb == 8) begin
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
        check(int'(acc) == exp, "R4 R5 R8 decoded byte", int'(acc), exp);
        nb = 0;
      end
    end
    check(!stuff_pend, "R6 stuff before EOP", {31'd0, stuff_pend}, 0);
    check(nb == 0, "R4 whole bytes", nb, 0);
    exp = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
    check(exp == -1, "R4 packet length", exp, -1);
    check(v == 3'b100, "R7 first SE0 bit", {29'd0, v}, 4);
    sample_cell(v);
    check(v == 3'b100, "R7 second SE0 bit", {29'd0, v}, 4);
    sample_cell(v);
    check(v == 3'b101, "R7 final J bit", {29'd0, v}, 5);
    check(!oe && !dp && !dm, "R7 R3 released", {29'd0, oe, dp, dm}, 0);
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (oe) decode();
    end
  end

  // driver: queue the expected bytes, then fire the request
  task automatic send(input bit hs, input int cnt, input logic [7:0] pid, input bit poke);
    int clr0 = clr_seen;
    exp_q.push_back(8'h80);
    if (hs) exp_q.push_back(int'(pid));
    else for (int i = 0; i < cnt - 1; i++) exp_q.push_back(int'(mem[i]));
    exp_q.push_back(-1);
    byte_count = CNT_W'(cnt);
    hs_pid = pid;
    if (hs) hs_start = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hs_start = 1'b0;
    check(oe && dm && !dp, "R2 acquire latency", {29'd0, oe, dp, dm}, 5);
    if (poke) begin
      repeat (20) @(negedge clk);
      byte_count = CNT_W'(5);
      start = 1'b1;
      hs_start = 1'b1;
      hs_pid = 8'h5A;
      @(negedge clk);
      start = 1'b0;
      hs_start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(clr_seen == clr0 + 1, "R10 one clear pulse", clr_seen - clr0, 1);
    check(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!oe && !dp && !dm && !busy && !pend_clr, "R1 idle outputs",
          {27'd0, oe, dp, dm, busy, pend_clr}, 0);
    check(dev_addr == '0, "R1 address clear", int'(dev_addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // plain data packet with mixed bits
    mem[0] = 8'hC3; mem[1] = 8'h5A;
    send(1'b0, 3, 8'h00, 1'b0);

    // stuffing inside and across bytes (R6)
    mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'h01; mem[3] = 8'h7E;
    send(1'b0, 5, 8'h00, 1'b0);

    // six ones ending the packet: stuff before SE0 (R6)
    mem[0] = 8'h12; mem[1] = 8'hFC;
    send(1'b0, 3, 8'h00, 1'b0);

    // pending address, then handshake must not commit it (R9, R8)
    @(negedge clk);
    addr_in = 7'h2A; addr_we = 1'b1;
    @(negedge clk);
    addr_we = 1'b0;
    send(1'b1, 2, 8'hD2, 1'b0);
    check(dev_addr == '0, "R9 handshake keeps address", int'(dev_addr), 0);
    send(1'b1, 2, 8'h5A, 1'b0);
    check(dev_addr == '0, "R9 NAK keeps address", int'(dev_addr), 0);

    // data packet commits (R9)
    mem[0] = 8'hA5;
    send(1'b0, 2, 8'h00, 1'b0);
    check(dev_addr == 7'h2A, "R9 data packet commits", int'(dev_addr), 'h2A);

    // SYNC only lengths (R4)
    send(1'b0, 1, 8'h00, 1'b0);
    send(1'b0, 0, 8'h00, 1'b0);

    // requests while busy ignored (R11)
    mem[0] = 8'h0F; mem[1] = 8'hF0; mem[2] = 8'h33;
    send(1'b0, 4, 8'h00, 1'b1);
    check(!oe && !busy, "R11 no extra packet", {30'd0, oe, busy}, 0);

    // longest payload with the narrow count
    for (int i = 0; i < 14; i++) mem[i] = 8'(i * 29 + 3);
    send(1'b0, 15, 8'h00, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule